// File: doc/BRIEF.md
# Timestamp-Compare Periodic Pulse Generator

This block turns a free-running time-of-day value (32-bit seconds plus 30-bit nanoseconds, supplied from outside) into timed pulses on two independent outputs. Each channel holds a target time. Once the time of day reaches that target, the channel drives a pulse whose width comes from a 4-bit code and whose active level is programmable. When re-arming is allowed, the channel then moves its target forward by a programmed period, carrying from nanoseconds into seconds, so the pulses repeat at a fixed interval.

Software loads targets and periods as 16-bit halves through a simple write port. A single shared configuration word holds each channel's width code, re-arm stop bit and polarity bit. A new target is held in staging and applied only when its seconds-high half is written, so a partly loaded value can never match. When the clock owner sets or steps the time of day, it pulses a per-channel step input. This moves that channel's target to the new seconds value plus three, at zero nanoseconds.

Each channel runs its own three-state machine. IDLE means no event is pending. ARMED means it is waiting for the time of day to reach the target. PULSE means the output is active. The transitions are: *commit* (target seconds-high write, from any state to ARMED); *step* (step input, from any state to ARMED); *match* (ARMED to PULSE when time ≥ target); *rearm* (PULSE to ARMED when time ≥ pulse end and re-arming is allowed); and *finish* (PULSE to IDLE when time ≥ pulse end and re-arming is stopped). With no event, IDLE and ARMED hold.

Top module: `tod_pulse_gen`

## Requirements
- R1: After reset both channels are IDLE. The configuration word resets to 0x000F: both channels active-high, re-arming stopped, width code 0. Both outputs are therefore low.
- R2: Writes to a channel's nanoseconds-low (offset 0), nanoseconds-high (offset 1) or seconds-low (offset 2) half only stage data and do not change the channel's behaviour. The write to seconds-high (offset 3) applies the whole staged target and arms the channel on that clock edge.
- R3: An ARMED channel matches when {time seconds, time ns} ≥ {target seconds, target ns}. This includes a target that already lies in the past. The output is active in the cycle after the edge at which the time first meets the target.
- R4: The pulse stays active until the first edge at which the time is ≥ target + width. Channel 0's width code sits in config bits 7:4 and channel 1's in bits 11:8. The codes map as follows: 0=100 ns, 1=500 ns, 2=1 µs, 3=5 µs, 4=10 µs, 5=50 µs, 6=100 µs, 7=500 µs, 8=1 ms, 9=5 ms, 10=10 ms, 11=50 ms, 12=100 ms, 13=200 ms.
- R5: Width codes 14 and 15 give a 100 ns pulse.
- R6: Config bit 1 (channel 0) and bit 3 (channel 1) select polarity. When the bit is 1 the output is high while pulsing and low otherwise; when it is 0 the levels are inverted.
- R7: While a channel's re-arm stop bit is 0 at the match, the target advances by the period (offsets 4/5 nanoseconds low/high, 6/7 seconds low/high). The new nanosecond value is reduced by 1,000,000,000 with a carry into seconds when the sum reaches that value, and the next pulse follows at the advanced target.
- R8: Config bit 0 (channel 0) and bit 2 (channel 1) stop re-arming. When the bit is 1 at the match, the channel fires once and then goes IDLE. A target of 0xFFFFFFFF seconds with the bit set keeps a channel silent.
- R9: A pulse on a channel's step input moves its target to step seconds + 3 with 0 ns and puts the channel in ARMED.
- R10: A seconds-high target write and a step on the same channel in the same cycle apply the written target.
- R11: Only bits 13:0 of a nanoseconds-high write are kept, so nanosecond values are 30 bits wide.
- R12: Channel c's registers sit at address 8·c + offset and the configuration word at address 16. The two channels run independently under any mix of settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_sec | input | 32 | Time of day, seconds |
| tod_ns | input | 30 | Time of day, nanoseconds (below 1e9) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| tod_step | input | 2 | Per-channel re-arm after a clock set or step |
| tod_step_sec | input | 32 | New seconds value used by tod_step |
| pulse_out | output | 2 | Channel pulse outputs |

## Verification
A write or step takes effect at the clock edge that samples it, so the new state shows on the outputs one cycle later. A match needs one more edge after arming: an already-past target shows its pulse two cycles after the seconds-high write. A time that reaches the target or the pulse end changes the output one cycle after that time is presented. The bench drives every input after the falling edge and compares the outputs after the next falling edge against a cycle-by-cycle model that keeps time as a single nanosecond count. Directed sections also count pulse lengths and rising edges against values worked out by hand.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int SEC_W     = 32;
    localparam int NS_W      = 30;
    localparam int REG_W     = 16;
    localparam int CODE_W    = 4;
    localparam int CH_STRIDE = 8;

    localparam logic [NS_W:0]      NS_WRAP       = 31'd1_000_000_000;
    localparam logic [SEC_W-1:0]   STEP_LEAD_SEC = 32'd3;

    // register offsets inside one channel window
    localparam int OFF_TNS_LO  = 0;
    localparam int OFF_TNS_HI  = 1;
    localparam int OFF_TSEC_LO = 2;
    localparam int OFF_TSEC_HI = 3;
    localparam int OFF_PNS_LO  = 4;
    localparam int OFF_PNS_HI  = 5;
    localparam int OFF_PSEC_LO = 6;
    localparam int OFF_PSEC_HI = 7;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_PULSE = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    function automatic logic [NS_W-1:0] width_ns(input logic [CODE_W-1:0] code);
        logic [NS_W-1:0] w;
        case (code)
            4'd1:    w = 30'd500;
            4'd2:    w = 30'd1_000;
            4'd3:    w = 30'd5_000;
            4'd4:    w = 30'd10_000;
            4'd5:    w = 30'd50_000;
            4'd6:    w = 30'd100_000;
            4'd7:    w = 30'd500_000;
            4'd8:    w = 30'd1_000_000;
            4'd9:    w = 30'd5_000_000;
            4'd10:   w = 30'd10_000_000;
            4'd11:   w = 30'd50_000_000;
            4'd12:   w = 30'd100_000_000;
            4'd13:   w = 30'd200_000_000;
            default: w = 30'd100;
        endcase
        return w;
    endfunction

    // add a seconds/nanoseconds amount with carry at one second
    function automatic tod_t tod_add(input tod_t a, input logic [SEC_W-1:0] b_sec,
                                     input logic [NS_W-1:0] b_ns);
        logic [NS_W:0] sum;
        tod_t          r;
        sum = {1'b0, a.ns} + {1'b0, b_ns};
        if (sum >= NS_WRAP) begin
            r.ns  = sum[NS_W-1:0] - NS_WRAP[NS_W-1:0];
            r.sec = a.sec + b_sec + 32'd1;
        end else begin
            r.ns  = sum[NS_W-1:0];
            r.sec = a.sec + b_sec;
        end
        return r;
    endfunction

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5,
    parameter int CFG_W  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [REG_W-1:0]            wr_data,
    output logic [NCH-1:0]              load,
    output logic [NCH-1:0][SEC_W-1:0]   load_sec,
    output logic [NCH-1:0][NS_W-1:0]    load_ns,
    output logic [NCH-1:0][SEC_W-1:0]   per_sec,
    output logic [NCH-1:0][NS_W-1:0]    per_ns,
    output logic [CFG_W-1:0]            cfg
);

    localparam int NS_HI_W = NS_W - REG_W;
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NCH * CH_STRIDE);
    localparam logic [CFG_W-1:0]  CFG_RST  = CFG_W'(16'h000F);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg <= CFG_RST;
        else if (wr_en && wr_addr == CFG_ADDR)
            cfg <= wr_data[CFG_W-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = c * CH_STRIDE;

        logic [REG_W-1:0]   tns_lo, tsec_lo, pns_lo, psec_lo, psec_hi;
        logic [NS_HI_W-1:0] tns_hi, pns_hi;

        logic sel_tns_lo, sel_tns_hi, sel_tsec_lo, sel_tsec_hi;
        logic sel_pns_lo, sel_pns_hi, sel_psec_lo, sel_psec_hi;

        assign sel_tns_lo  = wr_en && (wr_addr == ADDR_W'(BASE + OFF_TNS_LO));
        assign sel_tns_hi  = wr_en && (wr_addr == ADDR_W'(BASE + OFF_TNS_HI));
        assign sel_tsec_lo = wr_en && (wr_addr == ADDR_W'(BASE + OFF_TSEC_LO));
        assign sel_tsec_hi = wr_en && (wr_addr == ADDR_W'(BASE + OFF_TSEC_HI));
        assign sel_pns_lo  = wr_en && (wr_addr == ADDR_W'(BASE + OFF_PNS_LO));
        assign sel_pns_hi  = wr_en && (wr_addr == ADDR_W'(BASE + OFF_PNS_HI));
        assign sel_psec_lo = wr_en && (wr_addr == ADDR_W'(BASE + OFF_PSEC_LO));
        assign sel_psec_hi = wr_en && (wr_addr == ADDR_W'(BASE + OFF_PSEC_HI));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tns_lo  <= '0;
                tns_hi  <= '0;
                tsec_lo <= '0;
                pns_lo  <= '0;
                pns_hi  <= '0;
                psec_lo <= '0;
                psec_hi <= '0;
            end else begin
                if (sel_tns_lo)  tns_lo  <= wr_data;
                if (sel_tns_hi)  tns_hi  <= wr_data[NS_HI_W-1:0];
                if (sel_tsec_lo) tsec_lo <= wr_data;
                if (sel_pns_lo)  pns_lo  <= wr_data;
                if (sel_pns_hi)  pns_hi  <= wr_data[NS_HI_W-1:0];
                if (sel_psec_lo) psec_lo <= wr_data;
                if (sel_psec_hi) psec_hi <= wr_data;
            end
        end

        // the seconds-high write completes the staged target
        assign load[c]     = sel_tsec_hi;
        assign load_sec[c] = {wr_data, tsec_lo};
        assign load_ns[c]  = {tns_hi, tns_lo};
        assign per_sec[c]  = {psec_hi, psec_lo};
        assign per_ns[c]   = {pns_hi, pns_lo};
    end

endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [NS_W-1:0]   tod_ns,
    input  logic              load,
    input  logic [SEC_W-1:0]  load_sec,
    input  logic [NS_W-1:0]   load_ns,
    input  logic              step,
    input  logic [SEC_W-1:0]  step_sec,
    input  logic [SEC_W-1:0]  per_sec,
    input  logic [NS_W-1:0]   per_ns,
    input  logic [CODE_W-1:0] width_code,
    input  logic              stop_reload,
    input  logic              active_high,
    output logic              pulse,
    output ch_state_e         state,
    output logic [SEC_W-1:0]  tgt_sec,
    output logic [NS_W-1:0]   tgt_ns,
    output logic [SEC_W-1:0]  end_sec,
    output logic [NS_W-1:0]   end_ns
);

    ch_state_e st_q, st_d;
    tod_t      tgt_q, end_q, tod_now, tgt_next, end_next;
    logic      rearm_q;
    logic      hit_tgt, hit_end;

    assign tod_now  = '{sec: tod_sec, ns: tod_ns};
    assign hit_tgt  = tod_now >= tgt_q;
    assign hit_end  = tod_now >= end_q;
    assign tgt_next = tod_add(tgt_q, per_sec, per_ns);
    assign end_next = tod_add(tgt_q, '0, width_ns(width_code));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // transitions: commit, step, match, rearm, finish
    always_comb begin
        st_d = st_q;
        if (load || step) begin
            st_d = CH_ARMED;
        end else begin
            unique case (st_q)
                CH_IDLE:  st_d = CH_IDLE;
                CH_ARMED: if (hit_tgt) st_d = CH_PULSE;
                CH_PULSE: if (hit_end) st_d = rearm_q ? CH_ARMED : CH_IDLE;
                default:  st_d = CH_IDLE;
            endcase
        end
    end

    // target and pulse-end bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            end_q   <= '0;
            rearm_q <= 1'b0;
        end else if (load) begin
            tgt_q <= '{sec: load_sec, ns: load_ns};
        end else if (step) begin
            tgt_q <= '{sec: step_sec + STEP_LEAD_SEC, ns: '0};
        end else if (st_q == CH_ARMED && hit_tgt) begin
            end_q   <= end_next;
            rearm_q <= !stop_reload;
            if (!stop_reload) tgt_q <= tgt_next;
        end
    end

    // output decode
    always_comb begin
        pulse = (st_q == CH_PULSE) ? active_high : !active_high;
    end

    assign state   = st_q;
    assign tgt_sec = tgt_q.sec;
    assign tgt_ns  = tgt_q.ns;
    assign end_sec = end_q.sec;
    assign end_ns  = end_q.ns;

endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
    import tpg_pkg::*;
#(
    parameter  int NCH    = 2,
    localparam int ADDR_W = $clog2(NCH * CH_STRIDE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [NS_W-1:0]   tod_ns,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NCH-1:0]    tod_step,
    input  logic [SEC_W-1:0]  tod_step_sec,
    output logic [NCH-1:0]    pulse_out
);

    // stop/polarity pairs in the low nibble, width codes above
    localparam int CFG_W = 4 + CODE_W * NCH;

    logic [NCH-1:0]             ld;
    logic [NCH-1:0][SEC_W-1:0]  ld_sec, per_sec, ch_tgt_sec, ch_end_sec;
    logic [NCH-1:0][NS_W-1:0]   ld_ns, per_ns, ch_tgt_ns, ch_end_ns;
    logic [NCH-1:0][1:0]        ch_st;
    logic [NCH-1:0]             cfg_stop, cfg_pol;
    logic [CFG_W-1:0]           cfg;

    tpg_regs #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (ld),
        .load_sec (ld_sec),
        .load_ns  (ld_ns),
        .per_sec  (per_sec),
        .per_ns   (per_ns),
        .cfg      (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_state_e st_w;

        assign cfg_stop[c] = cfg[2*c];
        assign cfg_pol[c]  = cfg[2*c+1];
        assign ch_st[c]    = st_w;

        tpg_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tod_sec     (tod_sec),
            .tod_ns      (tod_ns),
            .load        (ld[c]),
            .load_sec    (ld_sec[c]),
            .load_ns     (ld_ns[c]),
            .step        (tod_step[c]),
            .step_sec    (tod_step_sec),
            .per_sec     (per_sec[c]),
            .per_ns      (per_ns[c]),
            .width_code  (cfg[4 + CODE_W*c +: CODE_W]),
            .stop_reload (cfg_stop[c]),
            .active_high (cfg_pol[c]),
            .pulse       (pulse_out[c]),
            .state       (st_w),
            .tgt_sec     (ch_tgt_sec[c]),
            .tgt_ns      (ch_tgt_ns[c]),
            .end_sec     (ch_end_sec[c]),
            .end_ns      (ch_end_ns[c])
        );
    end

endmodule

// File: rtl/tod_pulse_gen_chk.sv
module tod_pulse_gen_chk
    import tpg_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [SEC_W-1:0]           tod_sec,
    input logic [NS_W-1:0]            tod_ns,
    input logic [NCH-1:0]             ld,
    input logic [NCH-1:0][SEC_W-1:0]  ld_sec,
    input logic [NCH-1:0][NS_W-1:0]   ld_ns,
    input logic [NCH-1:0]             tod_step,
    input logic [SEC_W-1:0]           tod_step_sec,
    input logic [NCH-1:0][1:0]        ch_st,
    input logic [NCH-1:0][SEC_W-1:0]  ch_tgt_sec,
    input logic [NCH-1:0][NS_W-1:0]   ch_tgt_ns,
    input logic [NCH-1:0][SEC_W-1:0]  ch_end_sec,
    input logic [NCH-1:0][NS_W-1:0]   ch_end_ns,
    input logic [NCH-1:0]             cfg_pol,
    input logic [NCH-1:0]             pulse_out
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic quiet, at_tgt, at_end;
        assign quiet  = !ld[c] && !tod_step[c];
        assign at_tgt = {tod_sec, tod_ns} >= {ch_tgt_sec[c], ch_tgt_ns[c]};
        assign at_end = {tod_sec, tod_ns} >= {ch_end_sec[c], ch_end_ns[c]};

        a_r3_match_fires: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet && ch_st[c] == CH_ARMED && at_tgt) |=> (ch_st[c] == CH_PULSE));

        a_r4_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet && ch_st[c] == CH_PULSE && at_end) |=> (ch_st[c] != CH_PULSE));

        a_r4_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet && ch_st[c] == CH_PULSE && !at_end) |=> (ch_st[c] == CH_PULSE));

        a_r2_target_steady: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet && ch_st[c] != CH_ARMED) |=> ($stable(ch_tgt_sec[c]) && $stable(ch_tgt_ns[c])));

        a_r8_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet && ch_st[c] == CH_IDLE) |=> (ch_st[c] == CH_IDLE));

        a_r9_step_rearms: assert property (@(posedge clk) disable iff (!rst_n)
            (tod_step[c] && !ld[c]) |=> (ch_st[c] == CH_ARMED
                && ch_tgt_sec[c] == $past(tod_step_sec) + STEP_LEAD_SEC
                && ch_tgt_ns[c] == '0));

        a_r10_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ld[c] |=> (ch_st[c] == CH_ARMED && ch_tgt_sec[c] == $past(ld_sec[c])
                && ch_tgt_ns[c] == $past(ld_ns[c])));

        a_r6_output_cause: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pulse_out[c]) |-> (!$stable(ch_st[c]) || !$stable(cfg_pol[c])));
    end

endmodule

bind tod_pulse_gen tod_pulse_gen_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tod_sec      (tod_sec),
    .tod_ns       (tod_ns),
    .ld           (ld),
    .ld_sec       (ld_sec),
    .ld_ns        (ld_ns),
    .tod_step     (tod_step),
    .tod_step_sec (tod_step_sec),
    .ch_st        (ch_st),
    .ch_tgt_sec   (ch_tgt_sec),
    .ch_tgt_ns    (ch_tgt_ns),
    .ch_end_sec   (ch_end_sec),
    .ch_end_ns    (ch_end_ns),
    .cfg_pol      (cfg_pol),
    .pulse_out    (pulse_out)
);

// File: tb/tod_pulse_gen_bench.sv
module tod_pulse_gen_bench;

    localparam int     CLK_PERIOD = 10;
    localparam longint NSEC       = 64'd1000000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tod_sec = '0;
    logic [29:0] tod_ns = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  tod_step = '0;
    logic [31:0] tod_step_sec = '0;
    logic [1:0]  pulse_out;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    longint btod = 0;

    // reference model, time kept as one nanosecond count
    logic [15:0] m_reg [2][8];
    logic [15:0] m_cfg;
    longint      m_tgt [2];
    longint      m_end [2];
    int          m_st [2];
    bit          m_rearm [2];

    tod_pulse_gen u_tod_pulse_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .tod_sec      (tod_sec),
        .tod_ns       (tod_ns),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .tod_step     (tod_step),
        .tod_step_sec (tod_step_sec),
        .pulse_out    (pulse_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint bw(input logic [3:0] code);
        case (code)
            4'd1: return 500;       4'd2: return 1000;
            4'd3: return 5000;      4'd4: return 10000;
            4'd5: return 50000;     4'd6: return 100000;
            4'd7: return 500000;    4'd8: return 1000000;
            4'd9: return 5000000;   4'd10: return 10000000;
            4'd11: return 50000000; 4'd12: return 100000000;
            4'd13: return 200000000;
            default: return 100;
        endcase
    endfunction

    function automatic longint per_of(input int c);
        longint s, n;
        s = {m_reg[c][7], m_reg[c][6]};
        n = {m_reg[c][5][13:0], m_reg[c][4]};
        return s * NSEC + n;
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    task automatic apply_tod();
        tod_sec = 32'(btod / NSEC);
        tod_ns  = 30'(btod % NSEC);
    endtask

    // model of one rising edge, using the inputs now applied
    task automatic model_edge();
        longint now, s, n;
        now = btod;
        for (int c = 0; c < 2; c++) begin
            bit ld;
            ld = wr_en && (int'(wr_addr) == c*8 + 3);
            if (ld) begin
                s = {wr_data, m_reg[c][2]};
                n = {m_reg[c][1][13:0], m_reg[c][0]};
                m_tgt[c] = s * NSEC + n;
                m_st[c] = 1;
            end else if (tod_step[c]) begin
                s = tod_step_sec;
                m_tgt[c] = (s + 3) * NSEC;
                m_st[c] = 1;
            end else if (m_st[c] == 1 && now >= m_tgt[c]) begin
                m_end[c] = m_tgt[c] + bw(m_cfg[4+4*c +: 4]);
                m_rearm[c] = !m_cfg[2*c];
                if (!m_cfg[2*c]) m_tgt[c] = m_tgt[c] + per_of(c);
                m_st[c] = 2;
            end else if (m_st[c] == 2 && now >= m_end[c]) begin
                m_st[c] = m_rearm[c] ? 1 : 0;
            end
        end
        if (wr_en) begin
            if (wr_addr == 5'd16) m_cfg = wr_data;
            else if (wr_addr < 5'd16) m_reg[wr_addr[3]][wr_addr[2:0]] = wr_data;
        end
    endtask

    task automatic tick();
        model_edge();
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            int expv;
            expv = (m_st[c] == 2) ? int'(m_cfg[2*c+1]) : int'(!m_cfg[2*c+1]);
            check($sformatf("%s model ch%0d", cur_tag, c), int'(pulse_out[c]), expv);
        end
    endtask

    task automatic write_reg(input int addr, input logic [15:0] data);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic prog_target(input int c, input logic [31:0] sec, input logic [29:0] ns);
        write_reg(c*8 + 0, ns[15:0]);
        write_reg(c*8 + 1, {2'b00, ns[29:16]});
        write_reg(c*8 + 2, sec[15:0]);
        write_reg(c*8 + 3, sec[31:16]);
    endtask

    task automatic prog_period(input int c, input logic [31:0] sec, input logic [29:0] ns);
        write_reg(c*8 + 4, ns[15:0]);
        write_reg(c*8 + 5, {2'b00, ns[29:16]});
        write_reg(c*8 + 6, sec[15:0]);
        write_reg(c*8 + 7, sec[31:16]);
    endtask

    // advance time by d ns per cycle, counting high samples and rises on channel c
    task automatic run(input int cycles, input longint d, input int c,
                       output int highs, output int rises, output int first_hi);
        bit prev;
        prev = pulse_out[c];
        highs = 0; rises = 0; first_hi = -1;
        for (int k = 1; k <= cycles; k++) begin
            btod = btod + d;
            apply_tod();
            tick();
            if (pulse_out[c]) begin
                highs++;
                if (first_hi < 0) first_hi = k;
            end
            if (pulse_out[c] && !prev) rises++;
            prev = pulse_out[c];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int hi, ri, fh;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            for (int o = 0; o < 8; o++) m_reg[c][o] = '0;
            m_tgt[c] = 0; m_end[c] = 0; m_st[c] = 0; m_rearm[c] = 0;
        end
        m_cfg = 16'h000F;
        btod = 10 * NSEC;
        apply_tod();
        repeat (3) @(negedge clk);
        check("R1 reset outputs", int'(pulse_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(pulse_out), 0);

        // R6: ch0 active-low idles high
        cur_tag = "R6";
        write_reg(16, 16'h000D);
        check("R6 active-low idle", int'(pulse_out[0]), 1);
        write_reg(16, 16'h000F);
        check("R6 active-high idle", int'(pulse_out[0]), 0);

        // R2: staged halves do nothing; target 5 s lies in the past
        cur_tag = "R2";
        write_reg(0, 16'h0000);
        write_reg(1, 16'h0000);
        write_reg(2, 16'd5);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R2 staged no fire", int'(pulse_out[0]), 0);
        end
        cur_tag = "R3";
        write_reg(3, 16'h0000);
        check("R3 armed not yet", int'(pulse_out[0]), 0);
        tick();
        check("R3 past target fires", int'(pulse_out[0]), 1);
        cur_tag = "R8";
        tick();
        check("R8 single event ends", int'(pulse_out[0]), 0);
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R8 stays idle", int'(pulse_out[0]), 0);
        end

        // R4: code 2 = 1 us at 100 ns per cycle -> 10 high samples
        cur_tag = "R4";
        write_reg(16, 16'h002F);
        btod = 20 * NSEC; apply_tod();
        prog_target(0, 32'd20, 30'd500);
        run(30, 100, 0, hi, ri, fh);
        check("R4 width 1us high cycles", hi, 10);
        check("R4 first high cycle", fh, 5);

        // R5: code 15 -> 100 ns -> 1 high sample
        cur_tag = "R5";
        write_reg(16, 16'h00FF);
        btod = 21 * NSEC; apply_tod();
        prog_target(0, 32'd21, 30'd500);
        run(20, 100, 0, hi, ri, fh);
        check("R5 code 15 high cycles", hi, 1);

        // R7: reload 400 ns with carry across the second boundary
        cur_tag = "R7";
        write_reg(16, 16'h000E);
        prog_period(0, 32'd0, 30'd400);
        btod = 30 * NSEC + 999999000; apply_tod();
        prog_target(0, 32'd30, 30'd999999800);
        run(30, 100, 0, hi, ri, fh);
        check("R7 repeat events", ri, 6);
        check("R7 first event cycle", fh, 8);

        // R8: stop re-arm and park at far target
        cur_tag = "R8";
        write_reg(16, 16'h000F);
        prog_target(0, 32'hFFFF_FFFF, 30'd0);
        run(40, 100, 0, hi, ri, fh);
        check("R8 disabled channel silent", hi, 0);

        // R9: step ch1 to 100 s -> target 103 s
        cur_tag = "R9";
        btod = 102 * NSEC + 999999500; apply_tod();
        tod_step = 2'b10; tod_step_sec = 32'd100;
        tick();
        tod_step = 2'b00;
        run(12, 100, 1, hi, ri, fh);
        check("R9 step target fire cycle", fh, 5);
        check("R9 step single pulse", hi, 1);

        // R10: commit and step together; commit (200 s) wins over 143 s
        cur_tag = "R10";
        btod = 150 * NSEC; apply_tod();
        write_reg(8, 16'h0000);
        write_reg(9, 16'h0000);
        write_reg(10, 16'd200);
        wr_en = 1'b1; wr_addr = 5'd11; wr_data = 16'h0000;
        tod_step = 2'b10; tod_step_sec = 32'd140;
        tick();
        wr_en = 1'b0; tod_step = 2'b00;
        run(6, 100, 1, hi, ri, fh);
        check("R10 commit beats step", hi, 0);

        // R11: top two bits of ns-high dropped -> target exactly 50 s
        cur_tag = "R11";
        btod = 49 * NSEC + 999999900; apply_tod();
        write_reg(0, 16'h0000);
        write_reg(1, 16'hC000);
        write_reg(2, 16'd50);
        write_reg(3, 16'h0000);
        run(6, 100, 0, hi, ri, fh);
        check("R11 ns high masked fire cycle", fh, 1);

        // R12: random mix on both channels, checked every cycle by the model
        cur_tag = "R12";
        btod = 1000 * NSEC; apply_tod();
        for (int r = 0; r < 24; r++) begin
            logic [3:0] codes [5];
            logic [15:0] cfgw;
            codes[0] = 4'd0; codes[1] = 4'd1; codes[2] = 4'd2; codes[3] = 4'd14; codes[4] = 4'd15;
            cfgw = {4'h0, codes[$urandom_range(4)], codes[$urandom_range(4)], 4'($urandom_range(15))};
            write_reg(16, cfgw);
            for (int c = 0; c < 2; c++) begin
                longint t;
                prog_period(c, 32'd0, 30'($urandom_range(4000, 1100)));
                t = btod + longint'($urandom_range(3000));
                prog_target(c, 32'(t / NSEC), 30'(t % NSEC));
            end
            for (int k = 0; k < 200; k++) begin
                longint d;
                d = ($urandom_range(63) == 0) ? 64'd5000 : longint'($urandom_range(250, 50));
                if ($urandom_range(127) == 0) begin
                    tod_step = 2'($urandom_range(1, 3));
                    tod_step_sec = tod_sec;
                end
                btod = btod + d; apply_tod();
                tick();
                tod_step = 2'b00;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule